// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block watches the header of each incoming Ethernet frame and decides whether the receive path should keep it. Frame bytes arrive one per cycle on an 8-bit stream, marked by a valid strobe. A start-of-frame strobe comes with the first byte. The block captures the six destination-address bytes and the two type/length bytes, and skips the source address in between.

From these fields and the configuration inputs, the block forms an accept flag and a reason code. The configuration inputs are four programmable type IDs, unicast and multicast hash enables, a 64-bit hash table, a broadcast-reject bit and a copy-all bit. The reason code is meant to go into the receive descriptor status. The decision appears one cycle after the last type byte is captured and stays in place until the next frame starts. Frame storage, CRC checking and exact-address registers belong to other blocks.

Top module: `rx_accept_filter`

## Requirements
- R1: Byte 0 is the byte that comes with `sof_i`. Bytes 0..5 are the destination address, with byte 0 held in address bits [7:0]. Bytes 12 and 13 are the type field, high byte first. `decision_valid_o` rises one clock after the edge that samples byte 13, and not at that edge.
- R2: Once valid, `decision_valid_o`, `accept_o` and `reason_o` hold steady, even if the configuration changes. They hold until a byte with `sof_i` is sampled. That byte clears all three to 0 one clock later.
- R3: If the type field equals any of the four type IDs, the frame is accepted with reason 1. Type ID k sits at bits [16k+15:16k] of `cfg_type_id_i`.
- R4: A destination address of all ones is broadcast. It is accepted with reason 2 unless `cfg_no_bcast_i` is 1.
- R5: The hash index bit j (0..5) is the XOR of destination address bits j, j+6, …, j+42. The index selects one bit of `cfg_hash_table_i`.
- R6: Destination address bit 0 = 0 marks a unicast frame. When `cfg_uni_hash_en_i` is 1, a unicast frame whose hash bit is set is accepted with reason 3. A clear hash bit gives no acceptance.
- R7: Address bit 0 = 1 marks a group frame. With `cfg_multi_hash_en_i` set, a group frame that is not broadcast and whose hash bit is set is accepted with reason 4.
- R8: When `cfg_copy_all_i` is 1, every frame is accepted. The reason is 5 if no other rule matches.
- R9: When several rules match, the reason follows this priority: type ID, then broadcast, then hash, then copy-all. `accept_o` is 1 exactly when the reason is nonzero.
- R10: During and after reset, `decision_valid_o`, `accept_o` and `reason_o` are 0.
- R11: In these cases the frame is rejected with reason 0 when no other rule matches:
  - a unicast frame with unicast hashing disabled;
  - a group frame with multicast hashing disabled;
  - a broadcast frame that is rejected by `cfg_no_bcast_i` (the hash table is never consulted for broadcast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the first byte of a frame |
| data_valid_i | input | 1 | Byte on `data_i` is valid |
| data_i | input | 8 | Frame byte |
| cfg_type_id_i | input | 64 | Four type IDs, ID k at [16k+15:16k] |
| cfg_uni_hash_en_i | input | 1 | Enable hash acceptance of unicast frames |
| cfg_multi_hash_en_i | input | 1 | Enable hash acceptance of group frames |
| cfg_hash_table_i | input | 64 | Hash table, indexed by the 6-bit fold |
| cfg_no_bcast_i | input | 1 | Reject broadcast frames |
| cfg_copy_all_i | input | 1 | Accept every frame |
| decision_valid_o | output | 1 | Decision outputs are valid |
| accept_o | output | 1 | Frame accepted |
| reason_o | output | 3 | 0 none, 1 type, 2 broadcast, 3 unicast hash, 4 group hash, 5 copy-all |

## Verification
The assertions assume two things about the inputs. First, `sof_i` is only raised together with `data_valid_i`. Second, a new start of frame never lands in the same cycle as the header-complete pulse. The stimulus meets both: each header goes out as fourteen back-to-back valid bytes with `sof_i` only on the first, and every frame waits until the previous decision has been sampled. Configuration inputs change only between frames. The one exception is the hold test, which deliberately changes them while a decision is showing.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_TYPE  = 3'd1,
    RSN_BCAST = 3'd2,
    RSN_UHASH = 3'd3,
    RSN_MHASH = 3'd4,
    RSN_COPY  = 3'd5
  } rsn_e;
endpackage

// File: rtl/rx_hdr_capture.sv
module rx_hdr_capture #(
  parameter int ADDR_W = 48,
  parameter int TYPE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] da_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              hdr_done_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int TYPE_BYTES = TYPE_W / 8;
  localparam int HDR_BYTES  = 2 * ADDR_BYTES + TYPE_BYTES;
  localparam int CNT_W      = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] TYPE_FIRST = CNT_W'(2 * ADDR_BYTES);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] HDR_END    = CNT_W'(HDR_BYTES);

  logic [CNT_W-1:0]  cnt_q;
  logic [TYPE_W-1:0] type_q;
  logic              done_q;
  logic [7:0]        da_b [ADDR_BYTES];

  // cnt_q == 0: idle; counts bytes already taken in the current header
  wire take = data_valid_i && !sof_i && (cnt_q != '0) && (cnt_q != HDR_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      type_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (data_valid_i && sof_i) begin
        cnt_q <= CNT_W'(1);
      end else if (take) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q >= TYPE_FIRST) type_q <= {type_q[TYPE_W-9:0], data_i};
        if (cnt_q == HDR_LAST) done_q <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_da
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        da_b[b] <= '0;
      end else if (b == 0 && data_valid_i && sof_i) begin
        da_b[b] <= data_i;
      end else if (b != 0 && take && cnt_q == CNT_W'(b)) begin
        da_b[b] <= data_i;
      end
    end
    assign da_o[8*b +: 8] = da_b[b];
  end

  assign type_o     = type_q;
  assign hdr_done_o = done_q;
endmodule

// File: rtl/rx_hash_index.sv
module rx_hash_index #(
  parameter int ADDR_W = 48,
  parameter int HASH_W = 6
) (
  input  logic [ADDR_W-1:0] da_i,
  output logic [HASH_W-1:0] idx_o
);
  localparam int FOLDS = ADDR_W / HASH_W;

  for (genvar j = 0; j < HASH_W; j++) begin : g_bit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int k = 0; k < FOLDS; k++) acc = acc ^ da_i[k*HASH_W + j];
    end
    assign idx_o[j] = acc;
  end
endmodule

// File: rtl/rx_type_match.sv
module rx_type_match #(
  parameter int N_IDS  = 4,
  parameter int TYPE_W = 16
) (
  input  logic [TYPE_W-1:0]       type_i,
  input  logic [N_IDS*TYPE_W-1:0] ids_i,
  output logic [N_IDS-1:0]        hit_o,
  output logic                    any_o
);
  for (genvar k = 0; k < N_IDS; k++) begin : g_cmp
    assign hit_o[k] = (type_i == ids_i[k*TYPE_W +: TYPE_W]);
  end
  assign any_o = |hit_o;
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rx_filt_pkg::*;
#(
  parameter int N_TYPE_IDS = 4,
  parameter int ADDR_W     = 48,
  parameter int TYPE_W     = 16,
  parameter int HASH_W     = 6,
  localparam int TABLE_W   = 1 << HASH_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sof_i,
  input  logic                         data_valid_i,
  input  logic [7:0]                   data_i,
  input  logic [N_TYPE_IDS*TYPE_W-1:0] cfg_type_id_i,
  input  logic                         cfg_uni_hash_en_i,
  input  logic                         cfg_multi_hash_en_i,
  input  logic [TABLE_W-1:0]           cfg_hash_table_i,
  input  logic                         cfg_no_bcast_i,
  input  logic                         cfg_copy_all_i,
  output logic                         decision_valid_o,
  output logic                         accept_o,
  output logic [2:0]                   reason_o
);
  logic [ADDR_W-1:0]     da;
  logic [TYPE_W-1:0]     type_q;
  logic                  hdr_done;
  logic [HASH_W-1:0]     hash_idx;
  logic [N_TYPE_IDS-1:0] type_hits;
  logic                  type_hit;

  rx_hdr_capture #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_cap (
    .clk_i, .rst_ni, .sof_i, .data_valid_i, .data_i,
    .da_o(da), .type_o(type_q), .hdr_done_o(hdr_done)
  );

  rx_hash_index #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
    .da_i(da), .idx_o(hash_idx)
  );

  rx_type_match #(.N_IDS(N_TYPE_IDS), .TYPE_W(TYPE_W)) u_type (
    .type_i(type_q), .ids_i(cfg_type_id_i), .hit_o(type_hits), .any_o(type_hit)
  );

  wire is_bcast  = &da;
  wire is_group  = da[0];
  wire tbl_bit   = cfg_hash_table_i[hash_idx];
  wire bcast_ok  = is_bcast && !cfg_no_bcast_i;
  wire uhash_hit = cfg_uni_hash_en_i && !is_group && tbl_bit;
  wire mhash_hit = cfg_multi_hash_en_i && is_group && !is_bcast && tbl_bit;

  rsn_e rsn_d;
  always_comb begin
    if (type_hit)            rsn_d = RSN_TYPE;
    else if (bcast_ok)       rsn_d = RSN_BCAST;
    else if (uhash_hit)      rsn_d = RSN_UHASH;
    else if (mhash_hit)      rsn_d = RSN_MHASH;
    else if (cfg_copy_all_i) rsn_d = RSN_COPY;
    else                     rsn_d = RSN_NONE;
  end

  wire accept_d = type_hit | bcast_ok | uhash_hit | mhash_hit | cfg_copy_all_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
      reason_o         <= RSN_NONE;
    end else if (data_valid_i && sof_i) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
      reason_o         <= RSN_NONE;
    end else if (hdr_done) begin
      decision_valid_o <= 1'b1;
      accept_o         <= accept_d;
      reason_o         <= rsn_d;
    end
  end
endmodule

// File: rtl/rx_accept_filter_chk.sv
module rx_accept_filter_chk #(
  parameter int N_TYPE_IDS = 4,
  parameter int TYPE_W     = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         sof_i,
  input logic                         data_valid_i,
  input logic [N_TYPE_IDS*TYPE_W-1:0] cfg_type_id_i,
  input logic                         cfg_copy_all_i,
  input logic                         hdr_done,
  input logic [TYPE_W-1:0]            type_q,
  input logic                         decision_valid_o,
  input logic                         accept_o,
  input logic [2:0]                   reason_o
);
  function automatic logic id_hit(input logic [TYPE_W-1:0] t,
                                  input logic [N_TYPE_IDS*TYPE_W-1:0] ids);
    logic h;
    h = 1'b0;
    for (int k = 0; k < N_TYPE_IDS; k++) h = h | (t == ids[k*TYPE_W +: TYPE_W]);
    return h;
  endfunction

  wire new_frame = sof_i && data_valid_i;

  p_rise_after_hdr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decision_valid_o) |-> $past(hdr_done));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> (!accept_o && reason_o == 3'd0));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && !new_frame && !hdr_done) |=>
      (decision_valid_o && $stable(accept_o) && $stable(reason_o)));

  p_sof_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_frame |=> !decision_valid_o);

  p_type_reason_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_done && !new_frame && id_hit(type_q, cfg_type_id_i)) |=>
      (accept_o && reason_o == 3'd1));

  p_copy_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_done && !new_frame && cfg_copy_all_i) |=> accept_o);

  p_accept_reason_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> (accept_o == (reason_o != 3'd0)));
endmodule

bind rx_accept_filter rx_accept_filter_chk #(
  .N_TYPE_IDS(N_TYPE_IDS), .TYPE_W(TYPE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .data_valid_i(data_valid_i),
  .cfg_type_id_i(cfg_type_id_i), .cfg_copy_all_i(cfg_copy_all_i),
  .hdr_done(hdr_done), .type_q(type_q),
  .decision_valid_o(decision_valid_o), .accept_o(accept_o), .reason_o(reason_o)
);

// File: tb/rx_accept_filter_test.sv
`timescale 1ns/1ps
module rx_accept_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, valid = 1'b0;
  logic [7:0]  data = '0;
  logic [63:0] type_ids = {16'h8100, 16'h88F7, 16'h86DD, 16'h0800};
  logic        uni_en = 1'b0, multi_en = 1'b0, no_bc = 1'b0, copy_all = 1'b0;
  logic [63:0] htab = '0;
  logic        dv, acc;
  logic [2:0]  rsn;
  int          n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rx_accept_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .data_valid_i(valid), .data_i(data),
    .cfg_type_id_i(type_ids), .cfg_uni_hash_en_i(uni_en), .cfg_multi_hash_en_i(multi_en),
    .cfg_hash_table_i(htab), .cfg_no_bcast_i(no_bc), .cfg_copy_all_i(copy_all),
    .decision_valid_o(dv), .accept_o(acc), .reason_o(rsn)
  );

  typedef struct packed {
    logic [47:0] da;
    logic [15:0] ty;
    logic        uni, multi, nobc, copy, ht_ones;
    logic        exp_acc;
    logic [2:0]  exp_rsn;
  } vec_t;

  localparam logic [47:0] UC = 48'h665544332210;
  localparam logic [47:0] MC = 48'h0000005E0001;
  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;

  localparam vec_t VECS [17] = '{
    '{UC, 16'h1234, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd0}, // R11
    '{UC, 16'h0800, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'd1}, // R3
    '{UC, 16'h8100, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'd1}, // R3
    '{BC, 16'h1234, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'd2}, // R4
    '{BC, 16'h1234, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0, 3'd0}, // R4
    '{BC, 16'h86DD, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1, 3'd1}, // R9
    '{UC, 16'h1234, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1, 3'd3}, // R6
    '{UC, 16'h1234, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd0}, // R6
    '{UC, 16'h1234, 1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0, 3'd0}, // R11
    '{MC, 16'h1234, 1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1, 3'd4}, // R7
    '{MC, 16'h1234, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0, 3'd0}, // R11
    '{MC, 16'h1234, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 3'd0}, // R11
    '{UC, 16'h1234, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1, 3'd5}, // R8
    '{BC, 16'h1234, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1, 3'd2}, // R9
    '{UC, 16'h1234, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1, 3'd3}, // R9
    '{BC, 16'h88F7, 1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1, 3'd1}, // R9
    '{BC, 16'h1234, 1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0, 3'd0}  // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fold(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int k = 0; k < 8; k++) r = r ^ a[6*k +: 6];
    return r;
  endfunction

  // sends 14 header bytes; returns at the negedge after byte 13 was sampled
  task automatic send_hdr(input logic [47:0] da, input logic [15:0] ty);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      valid = 1'b1;
      sof   = (i == 0);
      if (i < 6)       data = da[8*i +: 8];
      else if (i < 12) data = 8'hA0 + 8'(i);
      else if (i == 12) data = ty[15:8];
      else             data = ty[7:0];
    end
    @(negedge clk);
    valid = 1'b0;
    sof   = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] da, input logic [15:0] ty,
                           input string req, input logic e_acc, input logic [2:0] e_rsn);
    send_hdr(da, ty);
    @(negedge clk);
    chk(req, {31'd0, dv}, 32'd1);
    chk(req, {31'd0, acc}, {31'd0, e_acc});
    chk(req, {29'd0, rsn}, {29'd0, e_rsn});
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] idx;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 valid", {31'd0, dv}, 32'd0);
    chk("R10 accept", {31'd0, acc}, 32'd0);
    chk("R10 reason", {29'd0, rsn}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 after", {29'd0, rsn, acc, dv}, 32'd0);

    foreach (VECS[v]) begin
      uni_en = VECS[v].uni; multi_en = VECS[v].multi;
      no_bc  = VECS[v].nobc; copy_all = VECS[v].copy;
      htab   = VECS[v].ht_ones ? '1 : '0;
      run_frame(VECS[v].da, VECS[v].ty, $sformatf("vec%0d", v),
                VECS[v].exp_acc, VECS[v].exp_rsn);
    end

    // R1: not valid at the edge sampling byte 13, valid one edge later
    uni_en = 0; multi_en = 0; no_bc = 0; copy_all = 0; htab = '0;
    send_hdr(BC, 16'h1234);
    chk("R1 early", {31'd0, dv}, 32'd0);
    @(negedge clk);
    chk("R1 valid", {31'd0, dv}, 32'd1);
    chk("R1 reason", {29'd0, rsn}, 32'd2);

    // R2: hold through config change, clear on next start of frame
    repeat (4) @(negedge clk);
    no_bc = 1'b1; copy_all = 1'b1;
    type_ids = '0;
    repeat (3) @(negedge clk);
    chk("R2 hold valid", {31'd0, dv}, 32'd1);
    chk("R2 hold accept", {31'd0, acc}, 32'd1);
    chk("R2 hold reason", {29'd0, rsn}, 32'd2);
    valid = 1'b1; sof = 1'b1; data = 8'h10;
    @(negedge clk);
    valid = 1'b0; sof = 1'b0;
    chk("R2 clear", {29'd0, rsn, acc, dv}, 32'd0);
    type_ids = {16'h8100, 16'h88F7, 16'h86DD, 16'h0800};
    no_bc = 1'b0; copy_all = 1'b0;

    // R5/R6: single table bit at the folded index
    idx = fold(48'h123456789ABC);
    uni_en = 1'b1; htab = 64'd1 << idx;
    run_frame(48'h123456789ABC, 16'h1234, "R5 R6 hit", 1'b1, 3'd3);
    htab = ~(64'd1 << idx);
    run_frame(48'h123456789ABC, 16'h1234, "R5 R6 miss", 1'b0, 3'd0);
    // R5/R7: group address, single bit
    uni_en = 1'b0; multi_en = 1'b1;
    idx = fold(48'hC0FFEE123401);
    htab = 64'd1 << idx;
    run_frame(48'hC0FFEE123401, 16'h1234, "R5 R7 hit", 1'b1, 3'd4);
    htab = ~(64'd1 << idx);
    run_frame(48'hC0FFEE123401, 16'h1234, "R5 R7 miss", 1'b0, 3'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule